// File: doc/BRIEF.md
# NAND Bus Strobe Sequencer

This block runs single-byte accesses to an 8-bit asynchronous NAND flash device. A 32-bit timing word sets how long each part of an access lasts. For writes and for reads it sets a setup length, a strobe length and a hold length, plus a turnaround gap. When the sequencer accepts a request, it pulls chip enable low. It then pulses the write or read strobe at the set point, drives or samples the data bus, and returns to idle after the hold phase.

Each request carries a direction bit and a two-bit kind tag. The tag makes the access a command byte, an address byte or a plain data byte. Command and address bytes raise the matching latch-enable line for as long as chip enable is low. When the direction changes between two accesses, the block inserts idle cycles with chip enable high before the next access. The write-protect line is released only while the device is selected. The device ready/busy pin is synchronised and shown as a status flag.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, the outputs are: mem_ce_n=1, mem_we_n=1, mem_re_n=1, mem_cle=0, mem_ale=0, bus_oe=0, mem_wp_n=0, req_ready=1, acc_done=0 and rd_data=0.
- R2: An accepted access is a setup phase, then a strobe phase, then a hold phase. Each phase lasts its field value plus one clock. The write fields are setup cfg_word[29:26], strobe [25:20] and hold [19:17]. The read fields are setup [16:13], strobe [12:7] and hold [6:4]. mem_ce_n is low during all three phases. The strobe line is low only during the strobe phase.
- R3: A write pulses only mem_we_n and a read pulses only mem_re_n. The two strobes are never low together.
- R4: During a write (req_write=1), bus_oe is high from the first setup cycle through the last hold cycle, and bus_dout carries the request byte. During a read, bus_oe stays low.
- R5: rd_data takes the value of bus_din present in the last strobe cycle of a read. It then holds that value until the next read captures a new one.
- R6: The kind codes are 0 = data, 1 = command, 2 = address and 3 = data. A command raises mem_cle and an address raises mem_ale, each for exactly the cycles in which mem_ce_n is low. Data raises neither line.
- R7: The turnaround gap is used only when an access has a different direction from the access before it. Its length is cfg_word[3:2] plus one cycle. During the gap mem_ce_n stays high and req_ready stays low. The first access after reset and any access in the same direction as the one before get no gap.
- R8: req_ready is high only when the block is idle. A request is accepted on a rising edge where req_valid and req_ready are both high. acc_done is high for exactly one cycle, the last hold cycle. req_ready returns high in the next cycle.
- R9: mem_wp_n is high exactly when mem_ce_n is low.
- R10: dev_ready follows mem_rb (1 = ready) through two flip-flops. A change on mem_rb shows on dev_ready after the second rising edge.
- R11: cfg_word bits 31, 30, 1 and 0 have no effect on any timing or output.
- R12: The timing word is sampled when the request is accepted. Changing cfg_word during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Idle, can accept a request |
| acc_done | output | 1 | High in the last hold cycle |
| rd_data | output | 8 | Byte captured by the last read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_cle | output | 1 | Command latch enable |
| mem_ale | output | 1 | Address latch enable |
| mem_wp_n | output | 1 | Write protect, active low |
| bus_oe | output | 1 | Data bus drive enable |
| bus_dout | output | 8 | Data bus output byte |
| bus_din | input | 8 | Data bus input byte |
| mem_rb | input | 1 | Device ready/busy pin |
| dev_ready | output | 1 | Synchronised ready flag |

## Verification
Two things can happen in the same cycle. In the last strobe cycle of a read, the data capture takes place while the phase moves into hold. The bench changes bus_din at every falling edge so that a capture one cycle early or late picks up a different byte. It then compares rd_data with the byte the bench drove in the computed last strobe cycle.

The second overlap is at the accepting edge: the turnaround decision and the sampling of the timing word happen on the same edge. The bench inverts cfg_word straight after acceptance and flips the direction between requests at random. It then checks every later cycle against a pin sequence worked out from the word captured at acceptance and from the previous direction.

// File: rtl/nstb_pkg.sv
package nstb_pkg;

  localparam int CFG_W = 32;
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_RSVD = 2'd3
  } kind_t;

  typedef struct packed {
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] turn;
  } timing_t;

  // Field positions follow the timing word layout; bits 31,30,1,0 are unused.
  function automatic timing_t decode_timing(input logic [CFG_W-1:0] w);
    timing_t t;
    t.wr_setup  = w[29:26];
    t.wr_strobe = w[25:20];
    t.wr_hold   = w[19:17];
    t.rd_setup  = w[16:13];
    t.rd_strobe = w[12:7];
    t.rd_hold   = w[6:4];
    t.turn      = w[3:2];
    return t;
  endfunction

  function automatic logic [CNT_W-1:0] setup_len(input timing_t t, input logic wr);
    return wr ? CNT_W'(t.wr_setup) : CNT_W'(t.rd_setup);
  endfunction

  function automatic logic [CNT_W-1:0] strobe_len(input timing_t t, input logic wr);
    return wr ? CNT_W'(t.wr_strobe) : CNT_W'(t.rd_strobe);
  endfunction

  function automatic logic [CNT_W-1:0] hold_len(input timing_t t, input logic wr);
    return wr ? CNT_W'(t.wr_hold) : CNT_W'(t.rd_hold);
  endfunction

endpackage

// File: rtl/nstb_level_sync.sv
module nstb_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d[0] = d;
    for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/nstb_req_latch.sv
module nstb_req_latch
  import nstb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  output timing_t           t_live,
  output timing_t           t_held,
  output logic              dir_held,
  output kind_t             kind_held,
  output logic [DATA_W-1:0] wdata_held
);
  timing_t           t_q, t_d;
  logic              dir_q, dir_d;
  kind_t             kind_q, kind_d;
  logic [DATA_W-1:0] wd_q, wd_d;

  assign t_live = decode_timing(cfg_word);

  // Next-state: load on acceptance, hold otherwise.
  always_comb begin
    t_d    = t_q;
    dir_d  = dir_q;
    kind_d = kind_q;
    wd_d   = wd_q;
    if (accept) begin
      t_d    = t_live;
      dir_d  = req_write;
      kind_d = kind_t'(req_kind);
      wd_d   = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      dir_q  <= 1'b0;
      kind_q <= KIND_DATA;
      wd_q   <= '0;
    end else begin
      t_q    <= t_d;
      dir_q  <= dir_d;
      kind_q <= kind_d;
      wd_q   <= wd_d;
    end
  end

  assign t_held     = t_q;
  assign dir_held   = dir_q;
  assign kind_held  = kind_q;
  assign wdata_held = wd_q;
endmodule

// File: rtl/nstb_phase_fsm.sv
module nstb_phase_fsm
  import nstb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  timing_t t_live,
  input  timing_t t_held,
  input  logic    dir_held,
  output phase_t  phase,
  output logic    accept,
  output logic    req_ready,
  output logic    acc_done,
  output logic    strobe_last
);
  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_dir_q, last_dir_d;
  logic             have_prev_q, have_prev_d;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    ph_d        = ph_q;
    cnt_d       = cnt_q;
    last_dir_d  = last_dir_q;
    have_prev_d = have_prev_q;
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          last_dir_d  = req_write;
          have_prev_d = 1'b1;
          if (have_prev_q && (last_dir_q != req_write)) begin
            ph_d  = PH_TURN;
            cnt_d = CNT_W'(t_live.turn);
          end else begin
            ph_d  = PH_SETUP;
            cnt_d = setup_len(t_live, req_write);
          end
        end
      end
      PH_TURN: begin
        if (cnt_zero) begin
          ph_d  = PH_SETUP;
          cnt_d = setup_len(t_held, dir_held);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_d  = PH_STROBE;
          cnt_d = strobe_len(t_held, dir_held);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          ph_d  = PH_HOLD;
          cnt_d = hold_len(t_held, dir_held);
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (cnt_zero) ph_d = PH_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      last_dir_q  <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      cnt_q       <= cnt_d;
      last_dir_q  <= last_dir_d;
      have_prev_q <= have_prev_d;
    end
  end

  assign phase       = ph_q;
  assign acc_done    = (ph_q == PH_HOLD) && cnt_zero;
  assign strobe_last = (ph_q == PH_STROBE) && cnt_zero;

  // R8: the cycle after the last hold cycle is idle
  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> req_ready);
  // R8: an accepted request makes the block busy at once
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R2: the strobe phase is entered only from setup
  a_r2_strobe_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_q == PH_STROBE) |-> $past(ph_q == PH_SETUP));
endmodule

// File: rtl/nstb_pin_drive.sv
module nstb_pin_drive
  import nstb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              strobe_last,
  input  logic              dir_held,
  input  kind_t             kind_held,
  input  logic [DATA_W-1:0] wdata_held,
  input  logic [DATA_W-1:0] bus_din,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_re_n,
  output logic              mem_cle,
  output logic              mem_ale,
  output logic              mem_wp_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic [DATA_W-1:0] rd_data
);
  logic              active;
  logic              in_strobe;
  logic              cap_en;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe = (phase == PH_STROBE);

  assign mem_ce_n = !active;
  assign mem_we_n = !(in_strobe && dir_held);
  assign mem_re_n = !(in_strobe && !dir_held);
  assign mem_cle  = active && (kind_held == KIND_CMD);
  assign mem_ale  = active && (kind_held == KIND_ADDR);
  assign mem_wp_n = active;
  assign bus_oe   = active && dir_held;
  assign bus_dout = wdata_held;

  assign cap_en = strobe_last && !dir_held;

  always_comb begin
    rd_d = rd_q;
    if (cap_en) rd_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R3: never both strobes at once
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_re_n));
  // R6: command and address latches are exclusive and only under chip enable
  a_r6_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cle && mem_ale));
  a_r6_latch_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cle || mem_ale) |-> !mem_ce_n);
  // R4: bus is never driven while a read strobe is active
  a_r4_oe_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> mem_re_n);
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nstb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              acc_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_re_n,
  output logic              mem_cle,
  output logic              mem_ale,
  output logic              mem_wp_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              mem_rb,
  output logic              dev_ready
);
  logic              rst_n_s;
  timing_t           t_live, t_held;
  logic              dir_held;
  kind_t             kind_held;
  logic [DATA_W-1:0] wdata_held;
  phase_t            phase;
  logic              accept;
  logic              str_last;

  // Reset asserts at once, releases on the clock.
  nstb_level_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  nstb_req_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .cfg_word(cfg_word),
    .req_write(req_write), .req_kind(req_kind), .req_wdata(req_wdata),
    .t_live(t_live), .t_held(t_held), .dir_held(dir_held),
    .kind_held(kind_held), .wdata_held(wdata_held)
  );

  nstb_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .req_write(req_write),
    .t_live(t_live), .t_held(t_held), .dir_held(dir_held), .phase(phase),
    .accept(accept), .req_ready(req_ready), .acc_done(acc_done),
    .strobe_last(str_last)
  );

  nstb_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n_s), .phase(phase), .strobe_last(str_last),
    .dir_held(dir_held), .kind_held(kind_held), .wdata_held(wdata_held),
    .bus_din(bus_din), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_re_n(mem_re_n), .mem_cle(mem_cle), .mem_ale(mem_ale),
    .mem_wp_n(mem_wp_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
    .rd_data(rd_data)
  );

  nstb_level_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk(clk), .rst_n(rst_n_s), .d(mem_rb), .q(dev_ready)
  );

  // R5: read data changes only right after a last strobe cycle
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(str_last) |-> $stable(rd_data));
  // R9: write protect released exactly while selected
  a_r9_wp_vs_ce: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_wp_n != mem_ce_n);
endmodule

// File: tb/nand_strobe_seq_tb_top.sv
module nand_strobe_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        req_valid, req_write;
  logic [1:0]  req_kind;
  logic [7:0]  req_wdata;
  logic        req_ready, acc_done;
  logic [7:0]  rd_data;
  logic        mem_ce_n, mem_we_n, mem_re_n, mem_cle, mem_ale, mem_wp_n;
  logic        bus_oe;
  logic [7:0]  bus_dout, bus_din;
  logic        mem_rb, dev_ready;

  int  n_total = 0;
  int  n_bad   = 0;
  bit  finished = 0;
  bit  have_prev = 0;
  bit  last_dir  = 0;

  nand_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_write(req_write), .req_kind(req_kind), .req_wdata(req_wdata),
    .req_ready(req_ready), .acc_done(acc_done), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_re_n(mem_re_n),
    .mem_cle(mem_cle), .mem_ale(mem_ale), .mem_wp_n(mem_wp_n),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din),
    .mem_rb(mem_rb), .dev_ready(dev_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Pin vector: {ce_n, we_n, re_n, cle, ale, oe, wp_n, ready, done}
  function automatic logic [8:0] obs_pins();
    return {mem_ce_n, mem_we_n, mem_re_n, mem_cle, mem_ale, bus_oe, mem_wp_n,
            req_ready, acc_done};
  endfunction

  function automatic logic [8:0] exp_pins(input int k, input int tt, input int ss,
                                          input int st, input int hh,
                                          input bit wr, input logic [1:0] kind);
    bit turn, strb, act;
    turn = (k < tt);
    strb = (k >= tt + ss) && (k < tt + ss + st);
    act  = !turn;
    return {!act, !(strb && wr), !(strb && !wr), act && kind == 2'd1,
            act && kind == 2'd2, act && wr, act, 1'b0,
            k == tt + ss + st + hh - 1};
  endfunction

  task automatic run_txn(input bit wr, input logic [1:0] kind, input logic [7:0] wd,
                         input logic [31:0] cfg, input bit perturb);
    int tt, ss, st, hh, total, cap_k;
    logic [8:0] msk [6];
    string      tag [6];
    bit         ok  [6];
    logic [8:0] av  [6];
    logic [8:0] ev  [6];
    bit         dout_ok;
    logic [7:0] cap_byte;
    logic [8:0] o, e;
    msk[0] = 9'b111000000; tag[0] = "R2";
    msk[1] = 9'b000110000; tag[1] = "R6";
    msk[2] = 9'b000001000; tag[2] = "R4";
    msk[3] = 9'b000000100; tag[3] = "R9";
    msk[4] = 9'b000000011; tag[4] = "R8";
    msk[5] = 9'b100000010; tag[5] = "R7";
    for (int i = 0; i < 6; i++) begin ok[i] = 1; av[i] = 0; ev[i] = 0; end
    dout_ok  = 1;
    cap_byte = 8'h00;
    ss = wr ? int'(cfg[29:26]) + 1 : int'(cfg[16:13]) + 1;
    st = wr ? int'(cfg[25:20]) + 1 : int'(cfg[12:7]) + 1;
    hh = wr ? int'(cfg[19:17]) + 1 : int'(cfg[6:4]) + 1;
    tt = (have_prev && last_dir != wr) ? int'(cfg[3:2]) + 1 : 0;
    have_prev = 1;
    last_dir  = wr;
    total = tt + ss + st + hh;
    cap_k = tt + ss + st - 1;

    @(negedge clk);
    cfg_word  = cfg;
    req_valid = 1'b1;
    req_write = wr;
    req_kind  = kind;
    req_wdata = wd;
    @(posedge clk);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        req_wdata = ~wd;
        if (perturb) cfg_word = ~cfg;
      end
      o = obs_pins();
      e = exp_pins(k, tt, ss, st, hh, wr, kind);
      for (int c = 0; c < 6; c++) begin
        if (c == 5 && k > tt) continue;
        if (ok[c] && ((o & msk[c]) != (e & msk[c]))) begin
          ok[c] = 0; av[c] = o; ev[c] = e;
        end
      end
      if (wr && k >= tt && bus_dout != wd) dout_ok = 0;
      bus_din = 8'($urandom);
      if (k == cap_k) cap_byte = bus_din;
    end
    for (int c = 0; c < 6; c++) chk(ok[c], tag[c], longint'(av[c]), longint'(ev[c]));
    chk(dout_ok, "R4 dout", longint'(bus_dout), longint'(wd));
    if (cfg[31:30] != 2'b00 || cfg[1:0] != 2'b00)
      chk(ok[0] && ok[4], "R11", longint'(av[0] | av[4]), longint'(ev[0] | ev[4]));
    if (perturb)
      chk(ok[0] && ok[4] && ok[5], "R12", longint'(av[0] | av[4]), longint'(ev[0] | ev[4]));
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 ready after hold", longint'(req_ready), 1);
    if (!wr) chk(rd_data == cap_byte, "R5 read capture", longint'(rd_data), longint'(cap_byte));
  endtask

  function automatic logic [31:0] mk_cfg(input int ws, input int wt, input int wh,
                                         input int rs, input int rt, input int rh,
                                         input int ta);
    return (32'(ws) << 26) | (32'(wt) << 20) | (32'(wh) << 17) | (32'(rs) << 13) |
           (32'(rt) << 7) | (32'(rh) << 4) | (32'(ta) << 2);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] typ;
    logic [7:0]  prev_rd;
    void'($urandom(32'd20240917));
    rst_n = 0; cfg_word = '0; req_valid = 0; req_write = 0; req_kind = 0;
    req_wdata = 0; bus_din = 0; mem_rb = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(obs_pins() == 9'b111000010, "R1 pins", longint'(obs_pins()), 9'b111000010);
    chk(rd_data == 8'h00 && dev_ready == 1'b0, "R1 rd_data/flag",
        longint'({rd_data, dev_ready}), 0);

    // R10: ready pin through two flops
    mem_rb = 1'b1;
    @(negedge clk);
    chk(dev_ready == 1'b0, "R10 one edge", longint'(dev_ready), 0);
    @(negedge clk);
    chk(dev_ready == 1'b1, "R10 two edges", longint'(dev_ready), 1);
    mem_rb = 1'b0;
    @(negedge clk);
    chk(dev_ready == 1'b1, "R10 fall one edge", longint'(dev_ready), 1);
    @(negedge clk);
    chk(dev_ready == 1'b0, "R10 fall two edges", longint'(dev_ready), 0);
    mem_rb = 1'b1;

    // Directed: typical timing, first access gets no turnaround (R7)
    typ = mk_cfg(1, 3, 1, 1, 5, 1, 3);
    run_txn(1, 2'd1, 8'h70, typ, 0);
    run_txn(1, 2'd2, 8'h12, typ, 0);
    run_txn(1, 2'd0, 8'hA5, typ, 0);
    run_txn(0, 2'd0, 8'h00, typ, 0);
    run_txn(0, 2'd3, 8'h00, typ, 1);
    run_txn(1, 2'd3, 8'h3C, typ, 0);
    // Minimum and maximum fields, with unused bits set (R11)
    run_txn(0, 2'd0, 8'h00, 32'h0000_0000, 0);
    run_txn(1, 2'd1, 8'hFF, 32'hC000_0003, 0);
    run_txn(0, 2'd2, 8'h00, 32'hFFFF_FFFF, 1);
    run_txn(1, 2'd0, 8'h81, 32'hFFFF_FFFF, 0);
    // R5: a write does not disturb rd_data
    prev_rd = rd_data;
    run_txn(1, 2'd0, 8'h55, typ, 0);
    chk(rd_data == prev_rd, "R5 hold over write", longint'(rd_data), longint'(prev_rd));

    // Random mix
    for (int n = 0; n < 120; n++) begin
      run_txn(1'($urandom), 2'($urandom), 8'($urandom), $urandom, 1'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule